// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block converts the levels on a small set of external pins into interrupt requests for a vector controller. Each pin is captured by one register on every clock, and the block compares that sample with the one from the clock before. Two channels are fully configurable: each can request while its pin is held low, or latch a flag on any change, on a falling edge or on a rising edge. A third channel detects edges only, and a single polarity bit chooses which edge it uses.

In the edge and change modes, a detected event sets a sticky flag whether the channel is enabled or not. Software clears the flag by writing a 1 to its bit in the clear register. The controller clears it by pulsing the channel's acknowledge line when it services the interrupt. In low-level mode no flag is kept: the request follows the sampled pin, so a pin that rises again before service takes its request with it. Configuration is written through a simple bus made of a write strobe, an address and a data word.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous active-low reset, all flags and requests are 0, all enables are 0, every control bit is 0, and the pin sample history reads high. A pin held high through reset therefore produces no edge.
- R2: Write address 0 holds control. Full channel k uses bits [2k+1:2k], with 00 meaning low level. In low level the channel's flag reads 0 and its request is high exactly while the sampled pin is low and the channel is enabled. The pin is sampled at the end of the clock it is driven in.
- R3: In low-level mode, if the pin returns high before service, the request drops in the cycle the high level is sampled, and nothing records that it was ever asserted.
- R4: Control code 01 (any change) sets the flag one clock after a changed sample is taken, for both rising and falling transitions.
- R5: Control code 10 sets the flag only on a high-to-low sample, and code 11 only on a low-to-high sample.
- R6: The edge-only channel (index 2 with two full channels) takes its polarity from control bit 4. A 0 selects the falling edge and a 1 selects the rising edge.
- R7: Write address 1 holds the enables, with bit k belonging to channel k. In the edge modes the flag sets even when the channel is disabled, and the request equals the flag ANDed with the enable.
- R8: A write to address 2 clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R9: A high acknowledge for channel k clears that channel's flag at the next clock.
- R10: An edge detected in the same cycle as a write-1 clear or an acknowledge for that channel wins, and the flag stays set.
- R11: A pulse that starts and ends between two rising clock edges is never sampled and leaves flags and requests unchanged.
- R12: A write to address 3 has no effect on any control, enable or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 3 | External pin levels, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 enable, 2 clear |
| wr_data_i | input | 5 | Register write data |
| ack_i | input | 3 | Per-channel service acknowledge, clears the flag |
| flag_o | output | 3 | Per-channel pending flag |
| irq_o | output | 3 | Per-channel interrupt request |

## Verification
Two functions can fall in the same cycle: setting a flag on a detected edge, and clearing that flag through a write of 1 or an acknowledge. The bench provokes the collision directly. It changes a pin, waits one clock so the new sample is compared against the old one, and issues the clear or the acknowledge in the cycle where the edge is being detected. It judges the result against a behavioural model that gives the edge priority. Long stretches of random pin, write and acknowledge traffic then produce further collisions in every mode.

// File: rtl/eis_pkg.sv
// Package: shared encodings for the external interrupt sense unit.
// Assumes a 2-bit register address space with three used locations.
package eis_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_EN   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CLR  = 2'd2;

endpackage

// File: rtl/eis_regs.sv
// Module: configuration registers of the sense unit.
// Holds the control word and the enable mask. Produces a 2-bit sense mode per channel and
// a one-cycle clear mask from writes to the clear address.
// Assumes the edge-only channels follow the full ones, and that their mode's top bit is fixed at 1.
module eis_regs #(
    parameter int NFULL = 2,
    parameter int NEDGE = 1,
    localparam int NCH  = NFULL + NEDGE,
    localparam int DW   = 2 * NFULL + NEDGE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [eis_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]              wr_data,
    output logic [2*NCH-1:0]           mode,
    output logic [NCH-1:0]             en,
    output logic [NCH-1:0]             clr
);
    import eis_pkg::*;

    logic [DW-1:0]  ctrl_q;
    logic [NCH-1:0] en_q;

    // Purpose: capture control and enable writes; other addresses leave them alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: ctrl_q <= wr_data;
                REG_EN:   en_q   <= wr_data[NCH-1:0];
                default:  ;
            endcase
        end
    end

    // Purpose: decode a write-1-to-clear strobe for the flags.
    always_comb begin
        clr = '0;
        if (wr_en && wr_addr == REG_CLR) clr = wr_data[NCH-1:0];
    end

    assign en = en_q;

    // Full channels read their two control bits; edge-only channels force the edge family.
    for (genvar k = 0; k < NCH; k++) begin : g_mode
        if (k < NFULL) begin : g_full
            assign mode[2*k +: 2] = ctrl_q[2*k +: 2];
        end else begin : g_edge
            assign mode[2*k +: 2] = {1'b1, ctrl_q[2*NFULL + (k - NFULL)]};
        end
    end

endmodule

// File: rtl/eis_chan.sv
// Module: one sense channel.
// Samples its pin once per clock and detects edges against the previous sample. It keeps a
// sticky flag in the edge modes and forms the request. Assumes the pin is already synchronous
// enough for a single sample register, and that the sample history idles high.
module eis_chan (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin,
    input  eis_pkg::sense_e mode,
    input  logic            en,
    input  logic            clr,
    input  logic            ack,
    output logic            flag,
    output logic            irq,
    output logic            evt,
    output logic            level,
    output logic            flag_raw
);
    import eis_pkg::*;

    logic pin_q;
    logic pin_p;
    logic flag_q;
    logic rise;
    logic fall;

    // Purpose: sample the pin and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
            pin_p <= 1'b1;
        end else begin
            pin_q <= pin;
            pin_p <= pin_q;
        end
    end

    assign rise  = pin_q & ~pin_p;
    assign fall  = ~pin_q & pin_p;
    assign level = (mode == SENSE_LOW);

    // Purpose: select which transition counts as an event for the current mode.
    always_comb begin
        case (mode)
            SENSE_ANY:  evt = rise | fall;
            SENSE_FALL: evt = fall;
            SENSE_RISE: evt = rise;
            default:    evt = 1'b0;
        endcase
    end

    // Purpose: sticky flag; an event outranks a clear, and level mode holds the flag at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (level)      flag_q <= 1'b0;
        else if (evt)        flag_q <= 1'b1;
        else if (clr || ack) flag_q <= 1'b0;
    end

    assign flag     = flag_q & ~level;
    assign flag_raw = flag_q;
    assign irq      = en & (level ? ~pin_q : flag_q);

endmodule

// File: rtl/ext_irq_sense.sv
// Module: external interrupt sense unit, top level.
// Combines the configuration registers with NFULL full-featured channels and NEDGE
// edge-only channels. Assumes bus writes take effect at the clock that samples them.
module ext_irq_sense #(
    parameter int NFULL = 2,
    parameter int NEDGE = 1,
    localparam int NCH  = NFULL + NEDGE,
    localparam int DW   = 2 * NFULL + NEDGE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             pin_i,
    input  logic                       wr_en_i,
    input  logic [eis_pkg::ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]              wr_data_i,
    input  logic [NCH-1:0]             ack_i,
    output logic [NCH-1:0]             flag_o,
    output logic [NCH-1:0]             irq_o
);
    import eis_pkg::*;

    logic [2*NCH-1:0] mode_w;
    logic [NCH-1:0]   en_w;
    logic [NCH-1:0]   clr_w;
    logic [NCH-1:0]   evt_w;
    logic [NCH-1:0]   level_w;
    logic [NCH-1:0]   flag_raw_w;

    eis_regs #(.NFULL(NFULL), .NEDGE(NEDGE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .mode    (mode_w),
        .en      (en_w),
        .clr     (clr_w)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        eis_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pin_i[k]),
            .mode     (sense_e'(mode_w[2*k +: 2])),
            .en       (en_w[k]),
            .clr      (clr_w[k]),
            .ack      (ack_i[k]),
            .flag     (flag_o[k]),
            .irq      (irq_o[k]),
            .evt      (evt_w[k]),
            .level    (level_w[k]),
            .flag_raw (flag_raw_w[k])
        );
    end

endmodule

// File: rtl/eis_checker.sv
// Module: property checker for the external interrupt sense unit, bound to the top.
// Assumes it observes the enable, clear, event and level signals driven inside the top.
module eis_checker #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ack_i,
    input logic [NCH-1:0] flag_o,
    input logic [NCH-1:0] irq_o,
    input logic [NCH-1:0] en_w,
    input logic [NCH-1:0] clr_w,
    input logic [NCH-1:0] evt_w,
    input logic [NCH-1:0] level_w,
    input logic [NCH-1:0] flag_raw_w
);
    for (genvar k = 0; k < NCH; k++) begin : g_chk
        // R7: a request never appears on a disabled channel
        a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[k] |-> en_w[k]);

        // R10: an event always leaves the flag set, whatever clear arrives with it
        a_r10_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_w[k] && !level_w[k]) |=> flag_raw_w[k]);

        // R8: a write-1 clear without a competing event empties the flag
        a_r8_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w[k] && !evt_w[k]) |=> !flag_raw_w[k]);

        // R9: an acknowledge without a competing event empties the flag
        a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[k] && !evt_w[k]) |=> !flag_raw_w[k]);

        // R2: level mode never leaves a latched flag behind
        a_r2_level_never_latches: assert property (@(posedge clk) disable iff (!rst_n)
            level_w[k] |=> !flag_raw_w[k]);

        // R2: the visible flag is zero whenever level mode is active
        a_r2_level_flag_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
            level_w[k] |-> !flag_o[k]);
    end
endmodule

bind ext_irq_sense eis_checker #(.NCH(NCH)) u_eis_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .en_w       (en_w),
    .clr_w      (clr_w),
    .evt_w      (evt_w),
    .level_w    (level_w),
    .flag_raw_w (flag_raw_w)
);

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
    localparam int PERIOD = 10;
    localparam int NFULL  = 2;
    localparam int NEDGE  = 1;
    localparam int NCH    = NFULL + NEDGE;
    localparam int DW     = 2 * NFULL + NEDGE;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] pin_i;
    logic           wr_en_i;
    logic [1:0]     wr_addr_i;
    logic [DW-1:0]  wr_data_i;
    logic [NCH-1:0] ack_i;
    logic [NCH-1:0] flag_o;
    logic [NCH-1:0] irq_o;

    ext_irq_sense #(.NFULL(NFULL), .NEDGE(NEDGE)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    always #(PERIOD/2) clk = ~clk;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    chk_on = 1'b0;
    bit    done   = 1'b0;
    string phase  = "R1";

    // Behavioural reference state
    logic [DW-1:0]  m_ctrl;
    logic [NCH-1:0] m_en;
    logic           m_s    [NCH];
    logic           m_p    [NCH];
    logic           m_flag [NCH];

    function automatic logic [1:0] m_mode(int k);
        if (k < NFULL) return m_ctrl[2*k +: 2];
        return {1'b1, m_ctrl[2*NFULL + (k - NFULL)]};
    endfunction

    // Reference model: advance one clock using the inputs presented at this edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0;
            m_en   = '0;
            for (int k = 0; k < NCH; k++) begin
                m_s[k] = 1'b1; m_p[k] = 1'b1; m_flag[k] = 1'b0;
            end
        end else begin
            for (int k = 0; k < NCH; k++) begin
                logic [1:0] md;
                logic       ev;
                logic       clr;
                md  = m_mode(k);
                ev  = 1'b0;
                if (md == 2'b01) ev = (m_s[k] != m_p[k]);
                if (md == 2'b10) ev = (!m_s[k] && m_p[k]);
                if (md == 2'b11) ev = (m_s[k] && !m_p[k]);
                clr = ack_i[k] || (wr_en_i && wr_addr_i == 2'd2 && wr_data_i[k]);
                if (md == 2'b00) m_flag[k] = 1'b0;
                else if (ev)     m_flag[k] = 1'b1;
                else if (clr)    m_flag[k] = 1'b0;
            end
            if (wr_en_i && wr_addr_i == 2'd0) m_ctrl = wr_data_i;
            if (wr_en_i && wr_addr_i == 2'd1) m_en   = wr_data_i[NCH-1:0];
            for (int k = 0; k < NCH; k++) begin
                m_p[k] = m_s[k];
                m_s[k] = pin_i[k];
            end
        end
    end

    // Comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            for (int k = 0; k < NCH; k++) begin
                logic lvl, ef, ei;
                lvl = (m_mode(k) == 2'b00);
                ef  = m_flag[k] & !lvl;
                ei  = m_en[k] & (lvl ? !m_s[k] : m_flag[k]);
                n_cmp += 2;
                if (flag_o[k] !== ef) begin
                    n_bad++;
                    $display("FAIL %s flag ch%0d at %0t: actual %b expected %b", phase, k, $time, flag_o[k], ef);
                end
                if (irq_o[k] !== ei) begin
                    n_bad++;
                    $display("FAIL %s irq ch%0d at %0t: actual %b expected %b", phase, k, $time, irq_o[k], ei);
                end
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        step();
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pin_i = '1; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; ack_i = '0;
        @(posedge clk);
        step();
        chk_on = 1'b1;
        step(2);
        rst_n = 1'b1;
        step(2);

        // R2: low level on the full channels, enabled
        phase = "R2";
        wr(2'd1, 5'b00111);
        pin_i[0] = 1'b0; step(3);
        pin_i[1] = 1'b0; step(2);
        // R3: the pin rises before service, so the request is lost
        phase = "R3";
        pin_i[0] = 1'b1; step(2);
        pin_i[1] = 1'b1; step(2);

        // R7: edge modes while disabled: ch0 any change, ch1 falling, ch2 rising
        phase = "R7";
        wr(2'd1, 5'b00000);
        wr(2'd0, 5'b1_10_01);
        pin_i = 3'b000; step(3);
        pin_i = 3'b111; step(3);
        wr(2'd1, 5'b00111); step(2);

        // R8: clear only ch0
        phase = "R8";
        wr(2'd2, 5'b00001); step(2);
        wr(2'd2, 5'b00110); step(2);

        // R4: any change on ch0 in both directions
        phase = "R4";
        pin_i[0] = 1'b0; step(3);
        wr(2'd2, 5'b00001);
        pin_i[0] = 1'b1; step(3);

        // R9: acknowledge clears
        phase = "R9";
        ack_i = 3'b001; step(); ack_i = '0; step(2);

        // R5: ch0 rising, ch1 falling
        phase = "R5";
        wr(2'd0, 5'b1_10_11);
        pin_i = 3'b000; step(3);
        wr(2'd2, 5'b00111);
        pin_i = 3'b111; step(3);
        wr(2'd2, 5'b00111); step();

        // R6: edge-only polarity
        phase = "R6";
        wr(2'd0, 5'b0_10_11);
        pin_i[2] = 1'b0; step(3);
        pin_i[2] = 1'b1; step(3);
        wr(2'd2, 5'b00100);
        wr(2'd0, 5'b1_10_11);
        pin_i[2] = 1'b0; step(3);
        pin_i[2] = 1'b1; step(3);

        // R10: edge in the same cycle as a clear or an acknowledge
        phase = "R10";
        wr(2'd0, 5'b1_01_01);
        pin_i[0] = 1'b0; step();
        wr(2'd2, 5'b00111); step(2);
        pin_i[1] = 1'b0; step();
        ack_i = 3'b010; step(); ack_i = '0; step(2);

        // R11: pulse between two rising edges is never sampled
        phase = "R11";
        wr(2'd2, 5'b00111); step();
        @(negedge clk); #1 pin_i[0] = 1'b1; #2 pin_i[0] = 1'b0;
        step(3);

        // R12: address 3 writes have no effect
        phase = "R12";
        wr(2'd3, 5'b11111); step(2);
        pin_i = 3'b111; step(3);

        // R4: mixed random traffic across all modes
        phase = "R4";
        for (int i = 0; i < 600; i++) begin
            pin_i   = NCH'($urandom);
            ack_i   = ($urandom % 6 == 0) ? NCH'($urandom) : '0;
            wr_en_i = ($urandom % 4 == 0);
            wr_addr_i = 2'($urandom);
            wr_data_i = DW'($urandom);
            step();
        end
        wr_en_i = 1'b0; ack_i = '0;
        step(2);
        finish_run();
    end
endmodule